// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block collects interrupt requests for a small 8-bit CPU and hands the core one vector at a time. Each hardware source from level 2 to level 15 has a request latch. A source pulse sets the latch. Acceptance by the CPU, or a software write of 0, clears it. Levels 2 and 3 and a latch-free trap input bypass all masking. Levels 4 to 15 need the master enable (IMF) and their own enable flag. Level 4 also needs a pin-enable bit. Levels 14 and 15 each take one of two sources, picked by a selector bit.

A three-state sequencer (SEQ_IDLE, SEQ_PRESENT, SEQ_RECOVER) picks the winning request in SEQ_IDLE. It registers the vector and raises the request line on the move SEQ_IDLE→SEQ_PRESENT, which happens when an eligible request exists. It holds both until the CPU pulses acknowledge. The move SEQ_PRESENT→SEQ_RECOVER, on acknowledge, clears the accepted latch and, for a maskable level, IMF. The move SEQ_RECOVER→SEQ_IDLE is unconditional and gives the core one cycle to drop the trap line before the next pick.

Software reaches the latches and enables over a byte-wide bus with writes and combinational reads.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all latches, enable flags, IMF, the selector bits and the pin-enable bit are 0, and `irq_req_o` is low.
- R2: A high `src_req_i[n]` (n = 2..15) in a cycle sets latch n at that clock edge. `src_req_i[1:0]` have no effect.
- R3: The latches read at address 0x3C (bits 7:2 = levels 7..2, bits 1:0 read 0) and at 0x3D (bits 7:0 = levels 15..8). Writing 0 to a bit clears that latch. Writing 1 leaves it unchanged and never sets it.
- R4: When a latch's source is high in the same cycle as a software write of 0 to that latch, the latch ends up set.
- R5: Levels 2 and 3 and `trap_req_i` are presented whatever the state of IMF and the enable flags.
- R6: Level n (4..15) is presented only while IMF and its enable flag are both 1. IMF is bit 0 of 0x38. The flags for levels 7..4 are bits 7:4 of 0x3A, and the flags for levels 15..8 are bits 7:0 of 0x3B. A latch that cannot be presented stays set.
- R7: Level 4 also requires the pin-enable bit, which is bit 3 of 0x38.
- R8: The level 14 latch takes `src_req_i[14]` when bit 1 of 0x38 is 0, and `alt_req_i[0]` when it is 1. The level 15 latch takes `src_req_i[15]` or `alt_req_i[1]` in the same way, selected by bit 2 of 0x38.
- R9: When several requests are eligible, the trap wins, then level 2, level 3 and so on, with level 15 last.
- R10: The vector for level n is 0xFFFE − 2n. The trap's vector is 0xFFFC.
- R11: An acknowledge sampled while `irq_req_o` is high clears the presented latch and drops `irq_req_o` at that edge. At least one further cycle passes before a new request is presented.
- R12: Acknowledging a level from 4 to 15 clears IMF. Acknowledging the trap, level 2 or level 3 leaves IMF unchanged.
- R13: While `irq_req_o` is high and no acknowledge has arrived, `irq_vec_o` stays constant. A request of higher priority that arrives meanwhile waits its turn.
- R14: The trap has no latch. The CPU holds `trap_req_i` until it acknowledges the trap vector and releases it in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 16 | Per-level request pulses; bits 1:0 unused |
| alt_req_i | input | 2 | Alternate sources for levels 14 (bit 0) and 15 (bit 1) |
| trap_req_i | input | 1 | Software/undefined-instruction trap request, held until acknowledged |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational) |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 16 | Vector address of the presented request |
| irq_ack_i | input | 1 | Single-cycle acknowledge from the CPU |

## Verification
Several rules are checked on every cycle by the assertions:
- a latch never rises without its source;
- a source beats a same-cycle software clear;
- acknowledge clears the latch and drops the request;
- the vector holds while presented;
- a maskable vector appears only if IMF was set, and its acknowledge clears IMF;
- a trap pending in SEQ_IDLE wins.

Other behaviour only the bench scenarios can show: the exact vector order when requests pile up, the register read-back map, selector steering, level 4 pin gating, and the fact that a masked or ignored request leaves nothing presented.

// File: rtl/irq_pkg.sv
package irq_pkg;
    // Level structure
    localparam int NLVL        = 16;
    localparam int LVL_W       = $clog2(NLVL);
    localparam int FIRST_LATCH = 2;
    localparam int FIRST_MASK  = 4;
    localparam int PIN_LVL     = 4;
    localparam int SHARED_A    = 14;
    localparam int SHARED_B    = 15;
    localparam int TRAP_CODE   = 1;
    localparam int N_ALT       = 2;

    // Vector table
    localparam int VEC_W = 16;
    localparam logic [VEC_W-1:0] VEC_TOP     = 16'hFFFE;
    localparam logic [VEC_W-1:0] VEC_MASK_HI = VEC_TOP - VEC_W'(2 * FIRST_MASK);
    localparam logic [VEC_W-1:0] VEC_TRAP    = VEC_TOP - VEC_W'(2 * TRAP_CODE);

    // Register bus
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h38;
    localparam logic [ADDR_W-1:0] A_EN_LO  = 8'h3A;
    localparam logic [ADDR_W-1:0] A_EN_HI  = 8'h3B;
    localparam logic [ADDR_W-1:0] A_LAT_LO = 8'h3C;
    localparam logic [ADDR_W-1:0] A_LAT_HI = 8'h3D;

    // Control register bit positions
    localparam int C_IMF   = 0;
    localparam int C_SEL_A = 1;
    localparam int C_SEL_B = 2;
    localparam int C_PIN   = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_PRESENT = 2'd1,
        SEQ_RECOVER = 2'd2
    } seq_state_e;

    function automatic logic [VEC_W-1:0] vec_of(input logic [LVL_W-1:0] lvl);
        return VEC_TOP - (VEC_W'(lvl) << 1);
    endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLVL-1:0]   src_req_i,
    input  logic [N_ALT-1:0]  alt_req_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [NLVL-1:0]   ack_clr_i,
    input  logic              imf_clr_i,
    output logic [NLVL-1:0]   latch_o,
    output logic [NLVL-1:0]   elig_o,
    output logic              imf_o
);
    localparam logic [NLVL-1:0] LATCH_MASK = {NLVL{1'b1}} << FIRST_LATCH;
    localparam logic [NLVL-1:0] EF_MASK    = {NLVL{1'b1}} << FIRST_MASK;

    logic [NLVL-1:0] latch_q;
    logic [NLVL-1:0] ef_q;
    logic            imf_q;
    logic            sel_a_q;
    logic            sel_b_q;
    logic            pin_en_q;
    logic [NLVL-1:0] hw_set;
    logic [NLVL-1:0] sw_keep;
    logic            unused_lo;

    assign unused_lo = ^src_req_i[FIRST_LATCH-1:0];

    // Source steering for each level
    for (genvar n = 0; n < NLVL; n++) begin : g_set
        if (n < FIRST_LATCH) begin : g_none
            assign hw_set[n] = 1'b0;
        end else if (n == SHARED_A) begin : g_shared_a
            assign hw_set[n] = sel_a_q ? alt_req_i[0] : src_req_i[n];
        end else if (n == SHARED_B) begin : g_shared_b
            assign hw_set[n] = sel_b_q ? alt_req_i[1] : src_req_i[n];
        end else begin : g_plain
            assign hw_set[n] = src_req_i[n];
        end
    end

    // Software write-0-to-clear mask
    always_comb begin
        sw_keep = '1;
        if (bus_wr_i && bus_addr_i == A_LAT_LO) begin
            sw_keep[DATA_W-1:0] = bus_wdata_i;
        end
        if (bus_wr_i && bus_addr_i == A_LAT_HI) begin
            sw_keep[NLVL-1:DATA_W] = bus_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= (hw_set | (latch_q & sw_keep & ~ack_clr_i)) & LATCH_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ef_q <= '0;
        end else if (bus_wr_i && bus_addr_i == A_EN_LO) begin
            ef_q[DATA_W-1:0] <= bus_wdata_i & EF_MASK[DATA_W-1:0];
        end else if (bus_wr_i && bus_addr_i == A_EN_HI) begin
            ef_q[NLVL-1:DATA_W] <= bus_wdata_i & EF_MASK[NLVL-1:DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imf_q    <= 1'b0;
            sel_a_q  <= 1'b0;
            sel_b_q  <= 1'b0;
            pin_en_q <= 1'b0;
        end else begin
            if (bus_wr_i && bus_addr_i == A_CTRL) begin
                sel_a_q  <= bus_wdata_i[C_SEL_A];
                sel_b_q  <= bus_wdata_i[C_SEL_B];
                pin_en_q <= bus_wdata_i[C_PIN];
            end
            if (imf_clr_i) begin
                imf_q <= 1'b0;
            end else if (bus_wr_i && bus_addr_i == A_CTRL) begin
                imf_q <= bus_wdata_i[C_IMF];
            end
        end
    end

    // Eligibility per level
    for (genvar n = 0; n < NLVL; n++) begin : g_elig
        if (n < FIRST_MASK) begin : g_nmi
            assign elig_o[n] = latch_q[n];
        end else if (n == PIN_LVL) begin : g_pin
            assign elig_o[n] = latch_q[n] & imf_q & ef_q[n] & pin_en_q;
        end else begin : g_mask
            assign elig_o[n] = latch_q[n] & imf_q & ef_q[n];
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CTRL: begin
                bus_rdata_o[C_IMF]   = imf_q;
                bus_rdata_o[C_SEL_A] = sel_a_q;
                bus_rdata_o[C_SEL_B] = sel_b_q;
                bus_rdata_o[C_PIN]   = pin_en_q;
            end
            A_EN_LO:  bus_rdata_o = ef_q[DATA_W-1:0];
            A_EN_HI:  bus_rdata_o = ef_q[NLVL-1:DATA_W];
            A_LAT_LO: bus_rdata_o = latch_q[DATA_W-1:0];
            A_LAT_HI: bus_rdata_o = latch_q[NLVL-1:DATA_W];
            default:  bus_rdata_o = '0;
        endcase
    end

    assign latch_o = latch_q;
    assign imf_o   = imf_q;

    // R3
    sw_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(hw_set)) == '0));

    // R4
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hw_set) & ~latch_q) == '0));

    // R11
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(ack_clr_i & ~hw_set) & latch_q) == '0));
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
    import irq_pkg::*;
(
    input  logic [NLVL-1:0]  elig_i,
    input  logic             trap_i,
    output logic             found_o,
    output logic [LVL_W-1:0] lvl_o,
    output logic [VEC_W-1:0] vec_o
);
    always_comb begin
        found_o = 1'b0;
        lvl_o   = '0;
        // Scan from lowest priority upward so the smallest index wins
        for (int n = NLVL - 1; n >= FIRST_LATCH; n--) begin
            if (elig_i[n]) begin
                found_o = 1'b1;
                lvl_o   = LVL_W'(n);
            end
        end
        if (trap_i) begin
            found_o = 1'b1;
            lvl_o   = LVL_W'(TRAP_CODE);
        end
    end

    assign vec_o = vec_of(lvl_o);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             found_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             ack_i,
    output logic             irq_req_o,
    output logic [VEC_W-1:0] irq_vec_o,
    output logic [NLVL-1:0]  ack_clr_o,
    output logic             imf_clr_o
);
    seq_state_e      state_q;
    seq_state_e      state_d;
    logic [LVL_W-1:0] cur_lvl_q;
    logic [VEC_W-1:0] vec_q;
    logic             take;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:    if (found_i) state_d = SEQ_PRESENT;
            SEQ_PRESENT: if (ack_i)   state_d = SEQ_RECOVER;
            SEQ_RECOVER: state_d = SEQ_IDLE;
            default:     state_d = SEQ_IDLE;
        endcase
    end

    // Output capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_lvl_q <= '0;
            vec_q     <= '0;
        end else if (state_q == SEQ_IDLE && found_i) begin
            cur_lvl_q <= lvl_i;
            vec_q     <= vec_i;
        end
    end

    assign take      = (state_q == SEQ_PRESENT) && ack_i;
    assign irq_req_o = (state_q == SEQ_PRESENT);
    assign irq_vec_o = vec_q;
    assign imf_clr_o = take && (cur_lvl_q >= LVL_W'(FIRST_MASK));

    for (genvar n = 0; n < NLVL; n++) begin : g_clr
        if (n < FIRST_LATCH) begin : g_none
            assign ack_clr_o[n] = 1'b0;
        end else begin : g_lvl
            assign ack_clr_o[n] = take && (cur_lvl_q == LVL_W'(n));
        end
    end

    // R13
    hold_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o && !ack_i |=> irq_req_o && $stable(irq_vec_o));

    // R11
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o && ack_i |=> !irq_req_o);

    // R11
    gap_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_req_o) |=> !irq_req_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLVL-1:0]   src_req_i,
    input  logic [N_ALT-1:0]  alt_req_i,
    input  logic              trap_req_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_req_o,
    output logic [VEC_W-1:0]  irq_vec_o,
    input  logic              irq_ack_i
);
    logic [NLVL-1:0]  latch;
    logic [NLVL-1:0]  elig;
    logic [NLVL-1:0]  ack_clr;
    logic             imf;
    logic             imf_clr;
    logic             found;
    logic [LVL_W-1:0] win_lvl;
    logic [VEC_W-1:0] win_vec;
    logic             unused_latch;

    assign unused_latch = ^latch;

    irq_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req_i   (src_req_i),
        .alt_req_i   (alt_req_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .ack_clr_i   (ack_clr),
        .imf_clr_i   (imf_clr),
        .latch_o     (latch),
        .elig_o      (elig),
        .imf_o       (imf)
    );

    irq_resolve u_resolve (
        .elig_i  (elig),
        .trap_i  (trap_req_i),
        .found_o (found),
        .lvl_o   (win_lvl),
        .vec_o   (win_vec)
    );

    irq_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .found_i   (found),
        .lvl_i     (win_lvl),
        .vec_i     (win_vec),
        .ack_i     (irq_ack_i),
        .irq_req_o (irq_req_o),
        .irq_vec_o (irq_vec_o),
        .ack_clr_o (ack_clr),
        .imf_clr_o (imf_clr)
    );

    // R6
    mask_needs_imf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o) && irq_vec_o <= VEC_MASK_HI |-> $past(imf));

    // R12
    imf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o && irq_ack_i && irq_vec_o <= VEC_MASK_HI |=> !imf);

    // R9
    trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o) && $past(trap_req_i) |-> irq_vec_o == VEC_TRAP);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_req = '0;
    logic [1:0]  alt_req = '0;
    logic        trap = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic        ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int hold_cyc = 0;
    bit done = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  d;

    always #2 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .alt_req_i(alt_req),
        .trap_req_i(trap), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_req_o(irq_req), .irq_vec_o(irq_vec), .irq_ack_i(ack));

    function automatic logic [15:0] vec(input int n);
        return 16'hFFFE - 16'(2 * n);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_vec(input logic [15:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string req);
        rd(a);
        chk(d == e, req, {8'h00, d}, {8'h00, e});
    endtask

    task automatic ctrl(input bit imf, input bit sa, input bit sb, input bit pin);
        wr(8'h38, {4'b0, pin, sb, sa, imf});
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        src_req[n] = 1'b1;
        @(negedge clk);
        src_req[n] = 1'b0;
    endtask

    task automatic pulse_alt(input int n);
        @(negedge clk);
        alt_req[n] = 1'b1;
        @(negedge clk);
        alt_req[n] = 1'b0;
    endtask

    task automatic quiet(input string req);
        repeat (8) @(negedge clk);
        chk(!irq_req, req, {15'd0, irq_req}, 16'd0);
    endtask

    task automatic drain(input string req);
        int guard = 0;
        while ((exp_q.size() != 0 || irq_req) && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 500) chk(1'b0, req, 16'(exp_q.size()), 16'd0);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            if (exp_q.size() != 0) chk(1'b0, "R9 leftover", 16'(exp_q.size()), 16'd0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: compare presented vectors against the scoreboard, then acknowledge
    initial begin
        logic [15:0] e;
        string t;
        forever begin
            @(negedge clk);
            if (rst_n && irq_req && !ack) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected request", irq_vec, 16'h0000);
                    e = irq_vec;
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(irq_vec == e, t, irq_vec, e);
                end
                for (int i = 0; i < hold_cyc; i++) begin
                    @(negedge clk);
                    chk(irq_req && irq_vec == e, "R13 hold", irq_vec, e);
                end
                ack = 1'b1;
                @(negedge clk);
                ack = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 16'd0, 16'd1);
        finish_run();
    end

    // Driver
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(!irq_req, "R1 req", {15'd0, irq_req}, 16'd0);
        rd_chk(8'h3C, 8'h00, "R1 latch lo");
        rd_chk(8'h3D, 8'h00, "R1 latch hi");
        rd_chk(8'h38, 8'h00, "R1 ctrl");
        rd_chk(8'h3A, 8'h00, "R1 enable lo");

        // R5 R10 level 2 non-maskable with IMF clear; R11 latch cleared by ack
        expect_vec(vec(2), "R5 R10 level 2");
        pulse(2);
        drain("R5 drain");
        rd_chk(8'h3C, 8'h00, "R11 latch cleared");

        // R14 trap without latch
        expect_vec(16'hFFFC, "R14 trap vector");
        @(negedge clk);
        trap = 1'b1;
        @(posedge clk);
        while (!ack) @(posedge clk);
        @(negedge clk);
        trap = 1'b0;
        drain("R14 drain");

        // R9 trap, level 2 and level 3 together
        expect_vec(16'hFFFC, "R9 trap first");
        expect_vec(vec(2), "R9 level 2 second");
        expect_vec(vec(3), "R9 level 3 third");
        @(negedge clk);
        trap = 1'b1; src_req[2] = 1'b1; src_req[3] = 1'b1;
        @(negedge clk);
        src_req[2] = 1'b0; src_req[3] = 1'b0;
        @(posedge clk);
        while (!ack) @(posedge clk);
        @(negedge clk);
        trap = 1'b0;
        drain("R9 drain");

        // R6 masked until IMF, R12 IMF cleared on maskable ack
        wr(8'h3A, 8'hF0);
        wr(8'h3B, 8'hFF);
        pulse(5);
        quiet("R6 masked without IMF");
        rd_chk(8'h3C, 8'h20, "R6 latch held");
        expect_vec(vec(5), "R6 R10 level 5");
        ctrl(1, 0, 0, 0);
        drain("R6 drain");
        rd_chk(8'h38, 8'h00, "R12 IMF cleared");

        // R12 non-maskable ack keeps IMF
        ctrl(1, 0, 0, 0);
        expect_vec(vec(2), "R12 level 2");
        pulse(2);
        drain("R12 drain");
        rd_chk(8'h38, 8'h01, "R12 IMF kept");

        // R7 level 4 pin enable
        pulse(4);
        quiet("R7 blocked without pin enable");
        rd_chk(8'h3C, 8'h10, "R7 latch held");
        expect_vec(vec(4), "R7 level 4");
        ctrl(1, 0, 0, 1);
        drain("R7 drain");
        ctrl(0, 0, 0, 0);

        // R3 write-0-to-clear, write 1 never sets
        pulse(6);
        pulse(7);
        rd_chk(8'h3C, 8'hC0, "R3 two latches");
        wr(8'h3C, 8'h80);
        rd_chk(8'h3C, 8'h80, "R3 clear one");
        wr(8'h3C, 8'hFF);
        rd_chk(8'h3C, 8'h80, "R3 ones no set lo");
        wr(8'h3D, 8'hFF);
        rd_chk(8'h3D, 8'h00, "R3 ones no set hi");
        wr(8'h3C, 8'h00);
        rd_chk(8'h3C, 8'h00, "R3 cleared");

        // R4 hardware set beats same-cycle clear
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h3D; bus_wdata = 8'h00; src_req[9] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; src_req[9] = 1'b0;
        rd_chk(8'h3D, 8'h02, "R4 set wins");
        wr(8'h3D, 8'h00);
        rd_chk(8'h3D, 8'h00, "R4 cleared after");

        // R2 bits 1:0 ignored
        ctrl(1, 0, 0, 1);
        @(negedge clk);
        src_req[1:0] = 2'b11;
        @(negedge clk);
        src_req[1:0] = 2'b00;
        quiet("R2 low bits ignored");
        rd_chk(8'h3C, 8'h00, "R2 low bits read 0");
        ctrl(0, 0, 0, 0);

        // R8 source selection
        pulse_alt(0);
        rd_chk(8'h3D, 8'h00, "R8 alt14 ignored sel 0");
        pulse(14);
        rd_chk(8'h3D, 8'h40, "R8 primary14 sel 0");
        wr(8'h3D, 8'h00);
        ctrl(0, 1, 0, 0);
        pulse(14);
        rd_chk(8'h3D, 8'h00, "R8 primary14 ignored sel 1");
        pulse_alt(0);
        rd_chk(8'h3D, 8'h40, "R8 alt14 sel 1");
        wr(8'h3D, 8'h00);
        ctrl(0, 0, 1, 0);
        pulse_alt(1);
        rd_chk(8'h3D, 8'h80, "R8 alt15 sel 1");
        expect_vec(vec(15), "R8 R10 level 15");
        ctrl(1, 0, 1, 0);
        drain("R8 drain");

        // R9 maskable order
        ctrl(0, 0, 0, 0);
        pulse(13);
        pulse(9);
        expect_vec(vec(9), "R9 level 9 before 13");
        ctrl(1, 0, 0, 0);
        drain("R9 mask drain a");
        rd_chk(8'h3D, 8'h20, "R9 level 13 still pending");
        expect_vec(vec(13), "R9 level 13");
        ctrl(1, 0, 0, 0);
        drain("R9 mask drain b");

        // R13 presented vector holds while a higher request arrives
        hold_cyc = 4;
        ctrl(1, 0, 0, 0);
        expect_vec(vec(10), "R13 level 10");
        expect_vec(vec(2), "R13 level 2 after");
        pulse(10);
        repeat (2) @(negedge clk);
        pulse(2);
        drain("R13 drain");
        hold_cyc = 0;

        finish_run();
    end
endmodule